// File: doc/BRIEF.md
# RAM Browser with Pseudorandom Fill

This block holds a 256-entry, byte-wide memory and a browsing pointer into it. Two single-cycle button pulses move the pointer forward or back one location. The current pointer and the byte stored at that location are presented as four hexadecimal nibbles, ready for a seven-segment display driver. The upper pair of digits carries the address and the lower pair carries the data.

A third pulse starts a fill. A maximal-length 8-bit linear feedback shift register then writes one pseudorandom byte per clock into every location, from address 0x00 up to 0xFF. A busy flag is high for the whole fill. When the last location is written, the block goes back to browsing by itself.

The button inputs are expected to be already debounced, with one clock-wide pulse per press. Display multiplexing is done outside this block.

Top module: `ram_browser`

## Requirements
- R1: After reset the pointer is 0x00, busy is low and the block is in browsing mode.
- R2: An up pulse in browsing mode increments the pointer by one on the next clock edge, and 0xFF wraps to 0x00.
- R3: A down pulse in browsing mode decrements the pointer by one on the next clock edge, and 0x00 wraps to 0xFF.
- R4: Up and down pulses asserted in the same cycle cancel, and the pointer is unchanged.
- R5: addr_hi is pointer bits 7:4 and addr_lo is pointer bits 3:0. data_hi is bits 7:4 and data_lo is bits 3:0 of the byte stored at the pointer. The data nibbles follow the pointer in the same cycle the pointer changes.
- R6: A fill pulse while busy is low raises busy at the next edge. Busy then stays high for exactly 256 cycles and drops on its own, and the block returns to browsing.
- R7: During a fill, location k (k = 0..255) receives the k-th state of the register. The first state written is the seed, 0x01 after reset. Each step is next = {q[6:0], q[7]^q[5]^q[4]^q[3]}.
- R8: The register state is kept between fills. The second fill starts from the state that follows the last byte written by the first fill.
- R9: Up and down pulses received while busy is high are ignored, and the pointer keeps its value through the fill.
- R10: A fill pulse received while busy is high is ignored. The fill is not restarted and still lasts 256 cycles.
- R11: The register state is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_pulse | input | 1 | One-cycle request to step the pointer forward |
| down_pulse | input | 1 | One-cycle request to step the pointer back |
| fill_pulse | input | 1 | One-cycle request to fill the memory with pseudorandom bytes |
| addr_hi | output | 4 | Upper hex digit of the pointer |
| addr_lo | output | 4 | Lower hex digit of the pointer |
| data_hi | output | 4 | Upper hex digit of the byte at the pointer |
| data_lo | output | 4 | Lower hex digit of the byte at the pointer |
| busy | output | 1 | High while a fill is in progress |

## Verification
The memory is filled, and then every location is visited twice: once by a full upward sweep and once by a full downward sweep. Each displayed byte is compared with a separately written model of the shift register. A wrong tap, wrong seed or off-by-one in the write address shows up as a mismatch at specific addresses, and the two sweep directions expose each wrap separately.

Up, down and fill pulses are injected in the middle of a fill. This separates a correctly guarded pointer and sequencer from one that moves or restarts; a restart would show up in the measured busy length.

A second fill is checked against the continued model. This distinguishes a register that keeps its state between fills from one that reloads the seed.

// File: rtl/ram_browser_pkg.sv
package ram_browser_pkg;

  parameter int unsigned RB_AW  = 8;
  parameter int unsigned RB_DW  = 8;
  parameter int unsigned RB_NIB = 4;

  localparam int unsigned RB_DEPTH = 1 << RB_AW;

  typedef logic [RB_AW-1:0] rb_addr_t;
  typedef logic [RB_DW-1:0] rb_byte_t;

  // Fibonacci step: shift left, feed back the parity of the tapped bits.
  function automatic rb_byte_t rb_lfsr_step(input rb_byte_t q, input rb_byte_t taps);
    return {q[RB_DW-2:0], ^(q & taps)};
  endfunction

  // Pointer move with modular wrap; simultaneous requests cancel.
  function automatic rb_addr_t rb_addr_move(input rb_addr_t a, input logic inc, input logic dec);
    rb_addr_t r;
    r = a;
    if (inc && !dec) r = a + rb_addr_t'(1);
    else if (dec && !inc) r = a - rb_addr_t'(1);
    return r;
  endfunction

endpackage

// File: rtl/rb_lfsr.sv
module rb_lfsr
  import ram_browser_pkg::*;
#(
  parameter rb_byte_t SEED = 8'h01,
  parameter rb_byte_t TAPS = 8'hB8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output rb_byte_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED;
    else if (adv) q <= rb_lfsr_step(q, TAPS);
  end

  p_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n) q != '0)
    else $error("lfsr reached zero");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> $stable(q))
    else $error("lfsr moved without a write");

endmodule

// File: rtl/rb_ram.sv
module rb_ram
  import ram_browser_pkg::*;
(
  input  logic     clk,
  input  logic     we,
  input  rb_addr_t waddr,
  input  rb_byte_t wdata,
  input  rb_addr_t raddr,
  output rb_byte_t rdata
);

  rb_byte_t mem [RB_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rb_addr_ctr.sv
module rb_addr_ctr
  import ram_browser_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up,
  input  logic     down,
  input  logic     hold,
  output rb_addr_t addr
);

  logic inc_evt, dec_evt;
  assign inc_evt = up & ~hold;
  assign dec_evt = down & ~hold;

  always_ff @(posedge clk) begin
    if (!rst_n) addr <= '0;
    else addr <= rb_addr_move(addr, inc_evt, dec_evt);
  end

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && !hold) |=> addr == rb_addr_t'($past(addr) + 1))
    else $error("up step wrong");

  p_down_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !up && !hold) |=> addr == rb_addr_t'($past(addr) - 1))
    else $error("down step wrong");

  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up && down) |=> $stable(addr))
    else $error("simultaneous presses moved pointer");

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(addr))
    else $error("pointer moved during fill");

endmodule

// File: rtl/rb_fill_seq.sv
module rb_fill_seq
  import ram_browser_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output logic     busy,
  output logic     wr_en,
  output rb_addr_t wr_addr
);

  rb_addr_t cnt;
  logic     last_evt;

  assign last_evt = busy && (cnt == '1);
  assign wr_en    = busy;
  assign wr_addr  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + rb_addr_t'(1);
      if (last_evt) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && cnt == '0))
    else $error("fill did not start at location zero");

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !busy)
    else $error("fill did not end after last location");

  p_norestart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_evt) |=> (busy && cnt == rb_addr_t'($past(cnt) + 1)))
    else $error("fill interrupted or restarted");

endmodule

// File: rtl/ram_browser.sv
module ram_browser
  import ram_browser_pkg::*;
#(
  parameter logic [7:0] SEED = 8'h01,
  parameter logic [7:0] TAPS = 8'hB8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_pulse,
  input  logic       down_pulse,
  input  logic       fill_pulse,
  output logic [3:0] addr_hi,
  output logic [3:0] addr_lo,
  output logic [3:0] data_hi,
  output logic [3:0] data_lo,
  output logic       busy
);

  rb_addr_t ptr;
  rb_addr_t wr_addr;
  rb_byte_t rnd;
  rb_byte_t rd_byte;
  logic     wr_en;

  rb_fill_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fill_pulse),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
  );

  rb_lfsr #(.SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (wr_en),
    .q     (rnd)
  );

  rb_ram u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (rnd),
    .raddr (ptr),
    .rdata (rd_byte)
  );

  rb_addr_ctr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (up_pulse),
    .down  (down_pulse),
    .hold  (busy),
    .addr  (ptr)
  );

  assign addr_hi = ptr[RB_AW-1 -: RB_NIB];
  assign addr_lo = ptr[RB_NIB-1:0];
  assign data_hi = rd_byte[RB_DW-1 -: RB_NIB];
  assign data_lo = rd_byte[RB_NIB-1:0];

endmodule

// File: tb/ram_browser_bench.sv
module ram_browser_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_pulse, down_pulse, fill_pulse;
  logic [3:0] addr_hi, addr_lo, data_hi, data_lo;
  logic       busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] exp_mem [256];
  logic [7:0] st;

  always #2 clk = ~clk;

  ram_browser u_ram_browser (
    .clk(clk), .rst_n(rst_n), .up_pulse(up_pulse), .down_pulse(down_pulse),
    .fill_pulse(fill_pulse), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .data_hi(data_hi), .data_lo(data_lo), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] model_next(input logic [7:0] q);
    logic fb;
    fb = q[7] ^ q[5] ^ q[4] ^ q[3];
    return {q[6:0], fb};
  endfunction

  function automatic int cur_addr();
    return {24'd0, addr_hi, addr_lo};
  endfunction

  task automatic press(input bit u, input bit d);
    @(negedge clk);
    up_pulse = u; down_pulse = d;
    @(negedge clk);
    up_pulse = 0; down_pulse = 0;
  endtask

  task automatic check_here(input string req);
    int a;
    a = cur_addr();
    chk({req, " data byte"}, {24'd0, data_hi, data_lo}, {24'd0, exp_mem[a]});
    chk("R5 data_hi nibble", {28'd0, data_hi}, {28'd0, exp_mem[a][7:4]});
  endtask

  task automatic run_fill();
    int ncyc;
    int a0;
    for (int k = 0; k < 256; k++) begin
      exp_mem[k] = st;
      st = model_next(st);
    end
    a0 = cur_addr();
    @(negedge clk);
    fill_pulse = 1;
    @(negedge clk);
    fill_pulse = 0;
    chk("R6 busy after start", {31'd0, busy}, 1);
    ncyc = 0;
    while (busy) begin
      ncyc++;
      up_pulse = 0; down_pulse = 0; fill_pulse = 0;
      if (ncyc == 10) up_pulse = 1;      // R9 stimulus
      if (ncyc == 40) down_pulse = 1;    // R9 stimulus
      if (ncyc == 70) fill_pulse = 1;    // R10 stimulus
      @(negedge clk);
    end
    up_pulse = 0; down_pulse = 0; fill_pulse = 0;
    chk("R6/R10 busy length", ncyc, 256);
    chk("R9 pointer kept through fill", cur_addr(), a0);
  endtask

  initial begin
    up_pulse = 0; down_pulse = 0; fill_pulse = 0; rst_n = 0;
    st = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 reset pointer", cur_addr(), 0);
    chk("R1 reset busy", {31'd0, busy}, 0);

    run_fill();

    // upward sweep over every location
    for (int i = 0; i < 256; i++) begin
      chk("R2 up pointer", cur_addr(), i);
      chk("R5 addr_lo nibble", {28'd0, addr_lo}, i % 16);
      check_here("R7 first fill");
      press(1, 0);
    end
    chk("R2 wrap FF to 00", cur_addr(), 0);

    // downward sweep, first step wraps
    for (int i = 0; i < 256; i++) begin
      press(0, 1);
      chk("R3 down pointer", cur_addr(), 255 - i);
      check_here("R7 down sweep");
    end
    chk("R3 back at 00", cur_addr(), 0);

    // simultaneous presses
    press(1, 1);
    chk("R4 cancel at 00", cur_addr(), 0);
    press(0, 1);
    press(1, 1);
    chk("R4 cancel at FF", cur_addr(), 255);
    repeat (5) press(1, 0);
    press(1, 1);
    chk("R4 cancel at 04", cur_addr(), 4);

    // second fill continues the sequence
    run_fill();
    for (int i = 0; i < 256; i++) begin
      check_here("R8 second fill");
      press(1, 0);
    end
    chk("R1 busy idle after fills", {31'd0, busy}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule